// File: doc/BRIEF.md
# Stop-Bit Tolerant UART Transceiver

This block is an asynchronous serial transceiver for 8-bit characters. Characters are sent least significant bit first, with no parity. A single oversampling enable, `os_tick`, paces both directions. It pulses once per sixteenth of a bit. The transmitter takes bytes through a valid/ready handshake and drives the serial output. The receiver reports each byte with a one-cycle strobe, together with a framing-error flag.

The transmitter and the receiver each have their own stop-bit setting. A node can therefore send two stop bits while accepting frames that carry only one. The receiver samples the first stop bit and then starts watching for a new start edge at once, whatever its own setting.

When the receiver is set for two stop bits, it still checks the second stop bit, but only if the line stays quiet until that bit's mid-sample. A falling edge that arrives earlier drops the check silently and begins a new frame. Each setting is captured when a frame begins, so a change never affects a frame in flight.

Top module: `uart_xcvr`

## Requirements
- R1: The serial output idles high while `tx_ready` is high. After a handshake (`tx_valid` and `tx_ready` both high at a clock edge), `tx_ready` drops and the line carries, in order: one low start bit, the 8 data bits with bit 0 first, and then the high stop bits.
- R2: Every transmitted bit lasts 16 `os_tick` pulses. `tx_ready` returns high exactly 160 ticks after the handshake when `tx_stop2` is 0, and 176 ticks after it when `tx_stop2` is 1.
- R3: `tx_stop2` is sampled at the handshake. Changing it during a frame does not alter that frame's length.
- R4: The receiver detects a falling edge on `rxd` and confirms the start bit low on the 8th tick. It then samples each later bit 16 ticks apart. `rx_valid` pulses for one cycle at the first stop bit's mid-sample, 153 ticks after the falling edge (two synchroniser stages included), and `rx_data` then holds the byte.
- R5: A low pulse on `rxd` that is high again by the 8th tick after its falling edge is rejected as a false start, and no byte is reported.
- R6: `rx_frame_err` is valid together with `rx_valid`. It is 1 when the first stop bit was sampled low and 0 when it was sampled high.
- R7: With `rx_stop2` at 1, frames that carry a single stop bit and follow each other back to back are all received correctly, with no framing error and no `rx_stop2_err`.
- R8: With `rx_stop2` at 1 and no falling edge after the first stop bit, the second stop bit is sampled 16 ticks after the first. If it is low, `rx_stop2_err` pulses for one cycle.
- R9: With `rx_stop2` at 0, only the first stop bit is checked, and `rx_stop2_err` never asserts, even when the line stays low after it.
- R10: `rx_stop2` is sampled at the start edge. Changing it during a frame does not alter which stop bits that frame checks.
- R11: A transmitter set to either stop count delivers correct bytes to a receiver set to either stop count, with no error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| tx_stop2 | input | 1 | Transmitter sends two stop bits when 1 |
| rx_stop2 | input | 1 | Receiver also checks a second stop bit when 1 |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte in `rx_data` |
| rx_frame_err | output | 1 | First stop bit was low (valid with `rx_valid`) |
| rx_stop2_err | output | 1 | One-cycle strobe: second stop bit was low |

## Verification
All timing is counted in `os_tick` pulses. The bench keeps a tick counter that advances at each rising edge that consumes a tick.

On the transmit side, `tx_ready` is due back exactly 160 or 176 ticks after the handshake. Serial bits are sampled near each bit's mid-point, 8 ticks after the bit begins, so that an off-by-one tick cannot move a sample onto a boundary.

On the receive side, the bench starts each driven start bit right after a tick. It then expects `rx_valid` exactly 153 ticks later, and `rx_stop2_err` exactly 16 ticks after that strobe. Outputs are read at the falling clock edge, and every wait for a result is bounded, so a missing strobe is reported rather than hanging the run.

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          tx_stop2,
  input  logic          rx_stop2,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          txd,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_frame_err,
  output logic          rx_stop2_err
);
  localparam int CW = $clog2(OSR);
  localparam int TB = $clog2(DW + 3);
  localparam int RB = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [TB-1:0] END1 = TB'(DW + 1);
  localparam logic [TB-1:0] END2 = TB'(DW + 2);
  localparam logic [RB-1:0] TOPB = RB'(DW - 1);

  // transmitter
  logic          tx_busy, tx_two;
  logic [CW-1:0] tx_cnt;
  logic [TB-1:0] tx_bit;
  logic [DW+2:0] tx_sh;

  assign tx_ready = !tx_busy;
  assign txd      = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_two  <= 1'b0;
      tx_cnt  <= '0;
      tx_bit  <= '0;
      tx_sh   <= '1;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        tx_busy <= 1'b1;
        tx_two  <= tx_stop2;
        tx_cnt  <= '0;
        tx_bit  <= '0;
        tx_sh   <= {2'b11, tx_data, 1'b0};
      end
    end else if (os_tick) begin
      if (tx_cnt == LAST) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[DW+2:1]};
        if (tx_bit == (tx_two ? END2 : END1)) tx_busy <= 1'b0;
        else tx_bit <= tx_bit + 1'b1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  // receiver
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP1, RX_STOP2} rx_st_e;
  rx_st_e        rx_st;
  logic          rx_m, rx_s, rx_q, rx_two;
  logic [CW-1:0] rx_cnt;
  logic [RB-1:0] rx_bit;
  logic [DW-1:0] rx_sh;
  logic          fall;

  assign fall = rx_q & ~rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_q <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st        <= RX_IDLE;
      rx_two       <= 1'b0;
      rx_cnt       <= '0;
      rx_bit       <= '0;
      rx_sh        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_stop2_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_stop2_err <= 1'b0;
      case (rx_st)
        RX_IDLE:
          if (fall) begin
            rx_st  <= RX_START;
            rx_cnt <= '0;
            rx_two <= rx_stop2;
          end
        RX_START:
          if (os_tick) begin
            if (rx_cnt == MID) begin
              rx_cnt <= '0;
              rx_bit <= '0;
              rx_st  <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_DATA:
          if (os_tick) begin
            if (rx_cnt == LAST) begin
              rx_cnt <= '0;
              rx_sh  <= {rx_s, rx_sh[DW-1:1]};
              if (rx_bit == TOPB) rx_st <= RX_STOP1;
              else rx_bit <= rx_bit + 1'b1;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_STOP1:
          if (os_tick) begin
            if (rx_cnt == LAST) begin
              rx_cnt       <= '0;
              rx_valid     <= 1'b1;
              rx_data      <= rx_sh;
              rx_frame_err <= ~rx_s;
              rx_st        <= rx_two ? RX_STOP2 : RX_IDLE;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_STOP2:
          if (fall) begin
            rx_st  <= RX_START;
            rx_cnt <= '0;
            rx_two <= rx_stop2;
          end else if (os_tick) begin
            if (rx_cnt == LAST) begin
              rx_stop2_err <= ~rx_s;
              rx_st        <= RX_IDLE;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R1
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !txd));

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !os_tick) |=> ($stable(txd) && !tx_ready));

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  stop2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop2_err |=> !rx_stop2_err);

  // R8
  stop2_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop2_err |-> !rx_valid);

  // R9
  stop2_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop2_err |-> rx_two);
endmodule

// File: tb/uart_xcvr_test.sv
module uart_xcvr_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_stop2 = 1'b0, rx_stop2 = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, txd, rx_valid, rx_frame_err, rx_stop2_err;
  logic [7:0] rx_data;
  logic drv = 1'b1, loop = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic os_tick, rxd;
  int tickn = 0;
  int n_run = 0, n_fail = 0;
  int rx_cnt = 0, s2_cnt = 0, s2_tick = 0;
  logic [7:0] rec_data [0:255];
  logic       rec_ferr [0:255];
  int         rec_tick [0:255];
  bit done = 0;

  always #10 clk = ~clk;
  assign os_tick = (tdiv == 2'd3);
  assign rxd = loop ? txd : drv;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    if (os_tick) tickn <= tickn + 1;
  end

  uart_xcvr uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .tx_stop2(tx_stop2),
    .rx_stop2(rx_stop2), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_frame_err(rx_frame_err), .rx_stop2_err(rx_stop2_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      rec_data[rx_cnt[7:0]] = rx_data;
      rec_ferr[rx_cnt[7:0]] = rx_frame_err;
      rec_tick[rx_cnt[7:0]] = tickn;
      rx_cnt = rx_cnt + 1;
    end
    if (rx_stop2_err) begin
      s2_cnt = s2_cnt + 1;
      s2_tick = tickn;
    end
  end

  function automatic int tx_len(input bit two);
    return 16 * (two ? 11 : 10);
  endfunction

  function automatic bit line_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!os_tick) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int nstop, input bit lvl, output int t0);
    drv = 1'b0;
    t0 = tickn;
    wait_ticks(16);
    for (int k = 0; k < 8; k++) begin
      drv = d[k];
      wait_ticks(16);
    end
    for (int k = 0; k < nstop; k++) begin
      drv = lvl;
      wait_ticks(16);
    end
    drv = 1'b1;
  endtask

  task automatic tx_send(input logic [7:0] d, output int dur);
    int t0;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    t0 = tickn;
    while (!tx_ready) @(negedge clk);
    dur = tickn - t0;
  endtask

  task automatic wait_rx(input int n);
    int g = 0;
    while (rx_cnt < n && g < 4000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int dur, t0, base, s2b;
    logic [7:0] d;
    bit two;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    chk(tx_ready && txd, "R1 reset idle", {tx_ready, txd}, 3);
    chk(!rx_valid && !rx_stop2_err, "R4 reset rx quiet", {rx_valid, rx_stop2_err}, 0);
    rst_n = 1'b1;
    wait_ticks(4);

    // R1: waveform of one frame, two stop bits
    tx_stop2 = 1'b1;
    d = 8'hA6;
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_ticks(8);
    for (int k = 0; k < 11; k++) begin
      chk(txd == line_bit(d, k) && !tx_ready, "R1 tx bit", txd, line_bit(d, k));
      wait_ticks(16);
    end
    while (!tx_ready) @(negedge clk);

    // R2: frame length for both settings
    for (int m = 0; m < 2; m++) begin
      tx_stop2 = m[0];
      tx_send(8'h3C, dur);
      chk(dur == tx_len(m[0]), "R2 tx length", dur, tx_len(m[0]));
    end

    // R3: config change mid-frame ignored
    tx_stop2 = 1'b0;
    @(negedge clk);
    tx_data = 8'h55;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    t0 = tickn;
    wait_ticks(40);
    tx_stop2 = 1'b1;
    while (!tx_ready) @(negedge clk);
    chk(tickn - t0 == tx_len(0), "R3 tx cfg latched", tickn - t0, tx_len(0));
    tx_stop2 = 1'b0;

    // R4, R7: back-to-back one-stop frames into a two-stop receiver
    rx_stop2 = 1'b1;
    wait_ticks(20);
    base = rx_cnt;
    s2b = s2_cnt;
    for (int i = 0; i < 5; i++) begin
      d = 8'(8'h11 * (i + 3));
      send_frame(d, 1, 1'b1, t0);
      wait_rx(base + i + 1);
      chk(rx_cnt == base + i + 1, "R7 frame count", rx_cnt, base + i + 1);
      chk(rec_data[8'(base + i)] == d && !rec_ferr[8'(base + i)], "R7 data",
          rec_data[8'(base + i)], d);
      chk(rec_tick[8'(base + i)] - t0 == 153, "R4 rx timing", rec_tick[8'(base + i)] - t0, 153);
    end
    wait_ticks(40);
    chk(s2_cnt == s2b, "R7 no stop2 error", s2_cnt, s2b);

    // R5: glitch rejected
    base = rx_cnt;
    drv = 1'b0;
    wait_ticks(4);
    drv = 1'b1;
    wait_ticks(200);
    chk(rx_cnt == base, "R5 false start", rx_cnt, base);

    // R6, R8: two low stop bits, two-stop receiver
    s2b = s2_cnt;
    send_frame(8'hC3, 2, 1'b0, t0);
    wait_ticks(30);
    chk(rx_cnt == base + 1 && rec_data[8'(base)] == 8'hC3, "R6 byte kept", rec_data[8'(base)], 8'hC3);
    chk(rec_ferr[8'(base)] == 1'b1, "R6 frame error", rec_ferr[8'(base)], 1);
    chk(s2_cnt == s2b + 1, "R8 stop2 error", s2_cnt, s2b + 1);
    chk(s2_tick - rec_tick[8'(base)] == 16, "R8 stop2 timing", s2_tick - rec_tick[8'(base)], 16);

    // R9: one-stop receiver, line held low
    rx_stop2 = 1'b0;
    wait_ticks(20);
    base = rx_cnt;
    s2b = s2_cnt;
    send_frame(8'h0F, 2, 1'b0, t0);
    wait_ticks(30);
    chk(rx_cnt == base + 1 && rec_ferr[8'(base)] == 1'b1, "R9 first stop only", rec_ferr[8'(base)], 1);
    chk(s2_cnt == s2b, "R9 no stop2 error", s2_cnt, s2b);

    // R10: rx config change mid-frame ignored
    base = rx_cnt;
    fork
      send_frame(8'hE1, 2, 1'b0, t0);
      begin wait_ticks(60); rx_stop2 = 1'b1; end
    join
    wait_ticks(30);
    chk(rx_cnt == base + 1 && rec_data[8'(base)] == 8'hE1, "R10 byte", rec_data[8'(base)], 8'hE1);
    chk(s2_cnt == s2b, "R10 rx cfg latched", s2_cnt, s2b);
    rx_stop2 = 1'b0;
    wait_ticks(20);

    // R11: random loopback over all stop-count pairs
    loop = 1'b1;
    wait_ticks(20);
    s2b = s2_cnt;
    for (int i = 0; i < 32; i++) begin
      d = 8'($urandom);
      two = 1'($urandom);
      tx_stop2 = two;
      rx_stop2 = 1'($urandom);
      base = rx_cnt;
      tx_send(d, dur);
      wait_rx(base + 1);
      chk(rx_cnt == base + 1 && rec_data[8'(base)] == d, "R11 loopback data", rec_data[8'(base)], d);
      chk(!rec_ferr[8'(base)], "R11 loopback ferr", rec_ferr[8'(base)], 0);
      chk(dur == tx_len(two), "R2 random length", dur, tx_len(two));
    end
    wait_ticks(40);
    chk(s2_cnt == s2b, "R11 no stop2 error", s2_cnt, s2b);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule